// File: doc/BRIEF.md
# 64-Point Two-Pass Complex FFT

This block computes a 64-point complex forward FFT by splitting the length into an 8 x 8 array. Samples stream in one per clock on a valid/ready handshake and are stored as a frame. A shared 8-point kernel first transforms every column of the frame. Each column result is rotated by a 64th-root-of-unity twiddle, and the same kernel then transforms the rows. The 64 results stream out in natural frequency order, each tagged with its bin number.

Two input frame buffers alternate, so one frame can load while the other is being transformed. One output buffer holds a finished frame until the consumer has taken all of it. Every radix-2 stage of the kernel halves its result to keep the data inside 16 bits. The whole transform therefore carries a fixed gain of 1/64.

Top module: `fft64_2d`

## Requirements
- R1: While reset is held and on the first cycle after it, `out_valid` is 0 and `in_ready` is 1.
- R2: When a frame buffer is free, a handshake (`in_valid` and `in_ready` both high at a rising edge) accepts one sample per clock. The k-th accepted sample of a frame, counted from 0, is time sample n = k. A frame is 64 samples, and a gapless frame into free buffers takes exactly 64 cycles with `in_ready` held high.
- R3: Each frame leaves as 64 handshakes. `out_idx` counts 0 to 63 in order, and `out_last` is 1 only on bin 63.
- R4: Every output is Y[k] = (1/64) * sum over n of x[n]·e^(-j2πnk/64). Real and imaginary parts are 16-bit two's complement and each stays within ±4 LSB of the exact value. This holds for inputs whose complex magnitude stays below 32768.
- R5: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_idx`, `out_re` and `out_im` hold their values into the next cycle.
- R6: Frames sent back to back, or queued while the output is stalled, come out in arrival order and each meets R4.
- R7: A full-scale DC input (every real part +32767, imaginary 0) gives bin 0 within 4 LSB of +32767, with no wrap to a negative value, and every other bin within 4 LSB of 0.
- R8: With `out_ready` held at 0 from an empty state, exactly 192 samples are accepted before `in_ready` stays 0. These are one frame in the output buffer and two in the input buffers. `in_ready` returns to 1 once the stored frames have been drained.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | A frame buffer can take a sample |
| in_re | input | 16 | Input real part, two's complement |
| in_im | input | 16 | Input imaginary part, two's complement |
| out_valid | output | 1 | Output bin present |
| out_ready | input | 1 | Consumer takes the output bin |
| out_re | output | 16 | Output real part, two's complement |
| out_im | output | 16 | Output imaginary part, two's complement |
| out_idx | output | 6 | Frequency bin of the present output |
| out_last | output | 1 | Present output is bin 63 |

## Verification
The DC-bin assertion relates the kernel's bin 0 to one eighth of the sum of its inputs. It therefore assumes that no kernel input drives bin 0 into saturation, which holds whenever input samples have complex magnitude below 32768. The stimulus keeps to that limit: random samples stay in ±8192 per component, the tone and impulse stay at or below 16000, and the only full-scale frame is pure DC, whose bin-0 path adds equal values. The stall and ordering assertions take for granted only that `out_ready` is a plain level from the consumer. The bench drives it from a fixed stall pattern.

// File: rtl/fft64_pkg.sv
// Package: shared constants, the complex sample type and fixed-point helpers
// for the two-pass 64-point transform. Assumes two's complement data and a
// Q1.15 twiddle format.
package fft64_pkg;

    localparam int DW  = 16;              // bits per real or imaginary part
    localparam int TWW = 16;              // twiddle word width (Q1.15)
    localparam int R   = 8;               // kernel length per pass
    localparam int NPT = R * R;           // transform length
    localparam int IW  = $clog2(NPT);     // bin / sample index width
    localparam int RW  = $clog2(R);       // row / column index width

    typedef struct packed {
        logic signed [DW-1:0] re;
        logic signed [DW-1:0] im;
    } cpx_t;

    typedef struct packed {
        logic signed [TWW-1:0] c;         // cos(2*pi*m/NPT)
        logic signed [TWW-1:0] s;         // sin(2*pi*m/NPT)
    } tw_t;

    // Clamp a wide signed value into DW bits.
    function automatic logic signed [DW-1:0] sat_dw(input longint v);
        longint hi;
        longint lo;
        hi = (longint'(1) <<< (DW - 1)) - 1;
        lo = -(longint'(1) <<< (DW - 1));
        if (v > hi)      return DW'(hi);
        else if (v < lo) return DW'(lo);
        else             return DW'(v);
    endfunction

    // Quarter-wave sine: round(32767 * sin(pi*i/32)) for i = 0..16.
    function automatic logic signed [TWW-1:0] qsin(input logic [4:0] i);
        case (i)
            5'd0:    return 16'sd0;
            5'd1:    return 16'sd3212;
            5'd2:    return 16'sd6393;
            5'd3:    return 16'sd9512;
            5'd4:    return 16'sd12539;
            5'd5:    return 16'sd15446;
            5'd6:    return 16'sd18204;
            5'd7:    return 16'sd20787;
            5'd8:    return 16'sd23170;
            5'd9:    return 16'sd25329;
            5'd10:   return 16'sd27245;
            5'd11:   return 16'sd28898;
            5'd12:   return 16'sd30273;
            5'd13:   return 16'sd31356;
            5'd14:   return 16'sd32137;
            5'd15:   return 16'sd32609;
            default: return 16'sd32767;
        endcase
    endfunction

    // Full-circle twiddle built from the quarter wave by quadrant symmetry.
    function automatic tw_t tw_lookup(input logic [IW-1:0] m);
        logic [IW-3:0]  r;
        logic [4:0]     rc;
        logic signed [TWW-1:0] sr;
        logic signed [TWW-1:0] sc;
        tw_t t;
        r  = m[IW-3:0];
        rc = 5'd16 - {1'b0, r};
        sr = qsin({1'b0, r});
        sc = qsin(rc);
        case (m[IW-1 -: 2])
            2'd0:    begin t.c = sc;  t.s = sr;  end
            2'd1:    begin t.c = -sr; t.s = sc;  end
            2'd2:    begin t.c = -sc; t.s = -sr; end
            default: begin t.c = sr;  t.s = -sc; end
        endcase
        return t;
    endfunction

endpackage

// File: rtl/fft_bfly2.sv
// Radix-2 butterfly with a fixed eighth-circle twiddle W8^TWK chosen at
// elaboration. Outputs are (a + t)/2 and (a - t)/2 with t = b * W8^TWK,
// floored, then saturated. Assumes TWK in 0..3.
module fft_bfly2
    import fft64_pkg::*;
#(
    parameter int TWK = 0
) (
    input  cpx_t a,
    input  cpx_t b,
    output cpx_t p,
    output cpx_t q
);

    longint t_re;
    longint t_im;

    if (TWK == 0) begin : g_w0
        // Purpose: unit twiddle passes b through.
        always_comb begin
            t_re = longint'(b.re);
            t_im = longint'(b.im);
        end
    end else if (TWK == 2) begin : g_w2
        // Purpose: multiply by -j (swap and negate).
        always_comb begin
            t_re = longint'(b.im);
            t_im = -longint'(b.re);
        end
    end else if (TWK == 1) begin : g_w1
        localparam longint K707 = 23170;
        localparam longint HALF = longint'(1) <<< (TWW - 2);
        // Purpose: multiply by (1 - j)/sqrt(2) with round to nearest.
        always_comb begin
            t_re = ((longint'(b.re) + longint'(b.im)) * K707 + HALF) >>> (TWW - 1);
            t_im = ((longint'(b.im) - longint'(b.re)) * K707 + HALF) >>> (TWW - 1);
        end
    end else begin : g_w3
        localparam longint K707 = 23170;
        localparam longint HALF = longint'(1) <<< (TWW - 2);
        // Purpose: multiply by (-1 - j)/sqrt(2) with round to nearest.
        always_comb begin
            t_re = ((longint'(b.im) - longint'(b.re)) * K707 + HALF) >>> (TWW - 1);
            t_im = (-(longint'(b.re) + longint'(b.im)) * K707 + HALF) >>> (TWW - 1);
        end
    end

    // Purpose: sum and difference with the 1/2 stage scaling.
    always_comb begin
        p.re = sat_dw((longint'(a.re) + t_re) >>> 1);
        p.im = sat_dw((longint'(a.im) + t_im) >>> 1);
        q.re = sat_dw((longint'(a.re) - t_re) >>> 1);
        q.im = sat_dw((longint'(a.im) - t_im) >>> 1);
    end

endmodule

// File: rtl/fft8_kernel.sv
// Combinational 8-point decimation-in-time FFT: bit-reversed input, three
// butterfly stages, natural-order output, total gain 1/8. Assumes R = 8.
module fft8_kernel
    import fft64_pkg::*;
(
    input  cpx_t x [R],
    output cpx_t y [R]
);

    localparam int NST = RW;

    cpx_t st [NST+1][R];

    for (genvar i = 0; i < R; i++) begin : g_in
        localparam int REV = ((i & 1) << 2) | (i & 2) | ((i >> 2) & 1);
        assign st[0][i] = x[REV];
        assign y[i]     = st[NST][i];
    end

    for (genvar s = 0; s < NST; s++) begin : g_stage
        for (genvar i = 0; i < R/2; i++) begin : g_bf
            localparam int H  = 1 << s;
            localparam int J  = i % H;
            localparam int A  = (i / H) * 2 * H + J;
            localparam int B  = A + H;
            localparam int TK = J * ((R/2) / H);
            fft_bfly2 #(.TWK(TK)) u_bf (
                .a (st[s][A]),
                .b (st[s][B]),
                .p (st[s+1][A]),
                .q (st[s+1][B])
            );
        end
    end

endmodule

// File: rtl/tw_rom.sv
// Twiddle table: for index m returns cos and sin of 2*pi*m/64 in Q1.15.
// The full circle is computed from a quarter-wave table.
module tw_rom
    import fft64_pkg::*;
(
    input  logic [IW-1:0]          idx,
    output logic signed [TWW-1:0]  cos_o,
    output logic signed [TWW-1:0]  sin_o
);

    tw_t t;

    // Purpose: quadrant-folded table lookup.
    always_comb begin
        t     = tw_lookup(idx);
        cos_o = t.c;
        sin_o = t.s;
    end

endmodule

// File: rtl/tw_cmul.sv
// Twiddle multiply y = x * (c - j s) with round to nearest (half up) and
// saturation to DW bits. Assumes c, s in Q1.15 and never -1.0.
module tw_cmul
    import fft64_pkg::*;
(
    input  cpx_t                   x,
    input  logic signed [TWW-1:0]  c,
    input  logic signed [TWW-1:0]  s,
    output cpx_t                   y
);

    localparam longint HALF = longint'(1) <<< (TWW - 2);

    longint pr;
    longint pi;

    // Purpose: full-precision products, then round and clamp.
    always_comb begin
        pr   = longint'(x.re) * longint'(c) + longint'(x.im) * longint'(s);
        pi   = longint'(x.im) * longint'(c) - longint'(x.re) * longint'(s);
        y.re = sat_dw((pr + HALF) >>> (TWW - 1));
        y.im = sat_dw((pi + HALF) >>> (TWW - 1));
    end

endmodule

// File: rtl/fft64_2d.sv
// Two-pass 64-point FFT. Input frames land in one of two alternating
// buffers. One shared 8-point kernel runs 8 column transforms (with twiddle
// rotation into a middle buffer), then 8 row transforms into an output
// buffer that streams bins 0..63. Sample n = 8a + b, bin k = c + 8d.
// Assumes out_ready is a plain level; one frame held in the output buffer.
module fft64_2d
    import fft64_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [DW-1:0] in_re,
    input  logic [DW-1:0] in_im,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [DW-1:0] out_re,
    output logic [DW-1:0] out_im,
    output logic [IW-1:0] out_idx,
    output logic          out_last
);

    typedef enum logic [1:0] {S_IDLE, S_COLP, S_ROWP} eng_t;

    localparam logic [IW-1:0] LAST_IDX = IW'(NPT - 1);
    localparam logic [RW-1:0] LAST_STP = RW'(R - 1);

    cpx_t bank [2][NPT];
    cpx_t mid  [NPT];
    cpx_t obuf [NPT];

    logic          wr_bank;
    logic [IW-1:0] wr_ptr;
    logic [1:0]    bank_full;
    logic          rd_bank;
    eng_t          state;
    logic [RW-1:0] step;
    logic          out_full;
    logic [IW-1:0] out_ptr;

    cpx_t          kin   [R];
    cpx_t          kout  [R];
    cpx_t          tw_y  [R];
    logic [IW-1:0] tw_idx [R];
    logic signed [TWW-1:0] tw_c [R];
    logic signed [TWW-1:0] tw_s [R];

    logic in_fire;
    logic out_fire;
    logic load_done;
    logic eng_start;
    logic eng_done;

    assign in_ready  = !bank_full[wr_bank];
    assign in_fire   = in_valid && in_ready;
    assign out_valid = out_full;
    assign out_fire  = out_full && out_ready;
    assign load_done = in_fire && (wr_ptr == LAST_IDX);
    assign eng_start = (state == S_IDLE) && bank_full[rd_bank] && !out_full;
    assign eng_done  = (state == S_ROWP) && (step == LAST_STP);

    // Purpose: write accepted samples into the loading buffer.
    always_ff @(posedge clk) begin
        if (in_fire) begin
            bank[wr_bank][wr_ptr] <= cpx_t'({in_re, in_im});
        end
    end

    // Purpose: load pointer and buffer selection for the input side.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr  <= '0;
            wr_bank <= 1'b0;
        end else if (in_fire) begin
            wr_ptr <= wr_ptr + 1'b1;
            if (wr_ptr == LAST_IDX) wr_bank <= ~wr_bank;
        end
    end

    // Purpose: buffer ownership, set by the loader and cleared by the engine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_full <= '0;
        end else begin
            if (load_done) bank_full[wr_bank] <= 1'b1;
            if (eng_done)  bank_full[rd_bank] <= 1'b0;
        end
    end

    // Purpose: engine sequencer, 8 column steps then 8 row steps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            step    <= '0;
            rd_bank <= 1'b0;
        end else begin
            case (state)
                S_IDLE: begin
                    step <= '0;
                    if (eng_start) state <= S_COLP;
                end
                S_COLP: begin
                    step <= step + 1'b1;
                    if (step == LAST_STP) state <= S_ROWP;
                end
                default: begin
                    step <= step + 1'b1;
                    if (step == LAST_STP) begin
                        state   <= S_IDLE;
                        rd_bank <= ~rd_bank;
                    end
                end
            endcase
        end
    end

    // Purpose: feed the shared kernel from the frame or the middle buffer.
    always_comb begin
        for (int a = 0; a < R; a++) begin
            if (state == S_ROWP) kin[a] = mid[{RW'(a), step}];
            else                 kin[a] = bank[rd_bank][{RW'(a), step}];
        end
    end

    fft8_kernel u_kernel (
        .x (kin),
        .y (kout)
    );

    // Purpose: per-lane twiddle index (column * bin) mod 64.
    always_comb begin
        for (int c = 0; c < R; c++) begin
            tw_idx[c] = IW'(step) * IW'(c);
        end
    end

    for (genvar c = 0; c < R; c++) begin : g_lane
        tw_rom u_rom (
            .idx   (tw_idx[c]),
            .cos_o (tw_c[c]),
            .sin_o (tw_s[c])
        );
        tw_cmul u_mul (
            .x (kout[c]),
            .c (tw_c[c]),
            .s (tw_s[c]),
            .y (tw_y[c])
        );
    end

    // Purpose: store rotated column results and final row results.
    always_ff @(posedge clk) begin
        if (state == S_COLP) begin
            for (int c = 0; c < R; c++) mid[{step, RW'(c)}] <= tw_y[c];
        end
        if (state == S_ROWP) begin
            for (int d = 0; d < R; d++) obuf[{RW'(d), step}] <= kout[d];
        end
    end

    // Purpose: output buffer ownership and read pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_full <= 1'b0;
            out_ptr  <= '0;
        end else begin
            if (eng_done) out_full <= 1'b1;
            if (out_fire) begin
                out_ptr <= out_ptr + 1'b1;
                if (out_ptr == LAST_IDX) out_full <= 1'b0;
            end
        end
    end

    assign out_re   = obuf[out_ptr].re;
    assign out_im   = obuf[out_ptr].im;
    assign out_idx  = out_ptr;
    assign out_last = (out_ptr == LAST_IDX);

    // ---------------- assertions ----------------
    int dc_sum;
    int dc_err;

    always_comb begin
        dc_sum = 0;
        for (int a = 0; a < R; a++) dc_sum = dc_sum + int'(kin[a].re);
        dc_err = int'(kout[0].re) * R - dc_sum;
    end

    // R4: kernel bin 0 tracks the input mean within the truncation budget
    assert_dc_bin_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_IDLE) |-> (dc_err <= 3 * R && dc_err >= -3 * R));

    // R5: a stalled output holds
    assert_out_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
        (out_valid && $stable(out_idx) && $stable(out_re) && $stable(out_im)));

    // R3: bins advance by one per handshake
    assert_idx_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !out_last) |=>
        (out_valid && out_idx == IW'($past(out_idx) + 1'b1)));

    // R3: the next frame starts again at bin 0
    assert_idx_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> (out_idx == '0));

    // R6: row results never land on a frame still being read out
    assert_no_overwrite_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ROWP) |-> !out_full);

    // R8: the input stalls only with both frame buffers occupied
    assert_in_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |-> (bank_full == 2'b11));

endmodule

// File: tb/fft64_2d_tb.sv
`timescale 1ns/1ps
module fft64_2d_tb_top;

    localparam int  CLK_PERIOD = 10;
    localparam int  NPTS       = 64;
    localparam int  TOL        = 4;
    localparam real PI         = 3.14159265358979;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_re = '0;
    logic [15:0] in_im = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [15:0] out_re;
    logic [15:0] out_im;
    logic [5:0]  out_idx;
    logic        out_last;

    int errors = 0;
    int checks = 0;
    int seed   = 32'h1234_5678;
    int fr_re  [3][NPTS];
    int fr_im  [3][NPTS];
    int got_re [3][NPTS];
    int got_im [3][NPTS];

    fft64_2d dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_re     (in_re),
        .in_im     (in_im),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_re    (out_re),
        .out_im    (out_im),
        .out_idx   (out_idx),
        .out_last  (out_last)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int rnd14();
        seed = seed * 1103515245 + 12345;
        return ((seed >>> 16) & 16'h3FFF) - 8192;
    endfunction

    // Send frames first..first+cnt-1 gaplessly; returns stall cycles seen.
    task automatic send_frames(input int first, input int cnt, output int stalls);
        stalls = 0;
        for (int f = first; f < first + cnt; f++) begin
            for (int n = 0; n < NPTS; n++) begin
                in_valid = 1'b1;
                in_re    = 16'(fr_re[f][n]);
                in_im    = 16'(fr_im[f][n]);
                while (!in_ready) begin
                    stalls++;
                    @(negedge clk);
                end
                @(negedge clk);
            end
        end
        in_valid = 1'b0;
    endtask

    // Take one frame into slot; stall=1 drops ready every third cycle.
    task automatic collect_frame(input int slot, input bit stall, input string req);
        int cnt = 0;
        int cyc = 0;
        bit held = 0;
        int h_idx = 0, h_re = 0, h_im = 0;
        while (cnt < NPTS) begin
            out_ready = stall ? ((cyc % 3) != 0) : 1'b1;
            if (held) begin
                chk(out_valid && int'(out_idx) == h_idx && int'($signed(out_re)) == h_re
                    && int'($signed(out_im)) == h_im, "R5", "held output",
                    int'($signed(out_re)), h_re);
                held = 0;
            end
            if (out_valid) begin
                if (out_ready) begin
                    got_re[slot][cnt] = int'($signed(out_re));
                    got_im[slot][cnt] = int'($signed(out_im));
                    chk(int'(out_idx) == cnt, req, "R3 bin tag", int'(out_idx), cnt);
                    chk(out_last == (cnt == NPTS - 1), req, "R3 last flag",
                        int'(out_last), int'(cnt == NPTS - 1));
                    cnt++;
                end else begin
                    held  = 1;
                    h_idx = int'(out_idx);
                    h_re  = int'($signed(out_re));
                    h_im  = int'($signed(out_im));
                end
            end
            cyc++;
            @(negedge clk);
        end
        out_ready = 1'b0;
    endtask

    // Compare a collected frame with a double-precision DFT scaled by 1/64.
    task automatic compare_frame(input int src, input int slot, input string req);
        for (int k = 0; k < NPTS; k++) begin
            real ar = 0.0, ai = 0.0;
            int er, ei;
            for (int n = 0; n < NPTS; n++) begin
                real th = 2.0 * PI * real'((n * k) % NPTS) / real'(NPTS);
                ar += real'(fr_re[src][n]) * $cos(th) + real'(fr_im[src][n]) * $sin(th);
                ai += real'(fr_im[src][n]) * $cos(th) - real'(fr_re[src][n]) * $sin(th);
            end
            ar = ar / real'(NPTS);
            ai = ai / real'(NPTS);
            er = $rtoi(ar >= 0.0 ? ar + 0.5 : ar - 0.5);
            ei = $rtoi(ai >= 0.0 ? ai + 0.5 : ai - 0.5);
            chk((got_re[slot][k] - er <= TOL) && (er - got_re[slot][k] <= TOL), req,
                $sformatf("bin %0d re", k), got_re[slot][k], er);
            chk((got_im[slot][k] - ei <= TOL) && (ei - got_im[slot][k] <= TOL), req,
                $sformatf("bin %0d im", k), got_im[slot][k], ei);
        end
    endtask

    task automatic run_one(input int slot, input bit stall, input string req);
        int st;
        fork
            send_frames(slot, 1, st);
            collect_frame(slot, stall, req);
        join
        compare_frame(slot, slot, req);
    endtask

    task automatic test_reset();
        chk(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
        chk(in_ready == 1'b1, "R1", "in_ready in reset", int'(in_ready), 1);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
        chk(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);
    endtask

    task automatic test_impulse();
        for (int n = 0; n < NPTS; n++) begin
            fr_re[0][n] = 0;
            fr_im[0][n] = 0;
        end
        fr_re[0][0] = 16000;
        run_one(0, 1'b0, "R4 impulse n=0");
        for (int n = 0; n < NPTS; n++) begin
            fr_re[0][n] = 0;
            fr_im[0][n] = 0;
        end
        fr_re[0][9]  = 12000;
        fr_im[0][9]  = -7000;
        run_one(0, 1'b0, "R4 impulse n=9");
    endtask

    task automatic test_tone();
        for (int n = 0; n < NPTS; n++) begin
            real th = 2.0 * PI * real'(5 * n) / real'(NPTS);
            fr_re[0][n] = $rtoi(12000.0 * $cos(th));
            fr_im[0][n] = $rtoi(12000.0 * $sin(th));
        end
        run_one(0, 1'b0, "R4 tone bin5");
    endtask

    task automatic test_fullscale_dc();
        for (int n = 0; n < NPTS; n++) begin
            fr_re[0][n] = 32767;
            fr_im[0][n] = 0;
        end
        run_one(0, 1'b0, "R7 full-scale DC");
        chk(got_re[0][0] > 32767 - TOL, "R7", "bin 0 not wrapped", got_re[0][0], 32767);
    endtask

    task automatic test_backpressure();
        for (int n = 0; n < NPTS; n++) begin
            fr_re[0][n] = rnd14();
            fr_im[0][n] = rnd14();
        end
        run_one(0, 1'b1, "R5 random with stalls");
    endtask

    task automatic test_back_to_back();
        int st;
        int t0, t1;
        for (int f = 0; f < 3; f++) begin
            for (int n = 0; n < NPTS; n++) begin
                fr_re[f][n] = rnd14();
                fr_im[f][n] = rnd14();
            end
        end
        fork
            begin
                t0 = $rtoi($realtime);
                send_frames(0, 1, st);
                t1 = $rtoi($realtime);
                chk(st == 0, "R2", "stalls in first frame", st, 0);
                chk((t1 - t0) / CLK_PERIOD == NPTS, "R2", "cycles per frame",
                    (t1 - t0) / CLK_PERIOD, NPTS);
                send_frames(1, 2, st);
            end
            begin
                collect_frame(0, 1'b0, "R6 frame 0");
                collect_frame(1, 1'b0, "R6 frame 1");
                collect_frame(2, 1'b0, "R6 frame 2");
            end
        join
        for (int f = 0; f < 3; f++) compare_frame(f, f, "R6 back to back");
    endtask

    task automatic test_fill_limit();
        int acc = 0;
        for (int f = 0; f < 3; f++) begin
            for (int n = 0; n < NPTS; n++) begin
                fr_re[f][n] = rnd14();
                fr_im[f][n] = rnd14();
            end
        end
        out_ready = 1'b0;
        for (int c = 0; c < 300; c++) begin
            in_valid = 1'b1;
            in_re    = acc < 192 ? 16'(fr_re[acc / NPTS][acc % NPTS]) : 16'd0;
            in_im    = acc < 192 ? 16'(fr_im[acc / NPTS][acc % NPTS]) : 16'd0;
            if (in_ready) acc++;
            @(negedge clk);
        end
        in_valid = 1'b0;
        chk(acc == 192, "R8", "samples accepted while stalled", acc, 192);
        chk(in_ready == 1'b0, "R8", "in_ready while full", int'(in_ready), 0);
        for (int f = 0; f < 3; f++) collect_frame(f, 1'b0, "R8 drain");
        for (int f = 0; f < 3; f++) compare_frame(f, f, "R6 queued frame");
        chk(in_ready == 1'b1, "R8", "in_ready after drain", int'(in_ready), 1);
    endtask

    initial begin : main
        repeat (3) @(negedge clk);
        test_reset();
        test_impulse();
        test_tone();
        test_fullscale_dc();
        test_backpressure();
        test_back_to_back();
        test_fill_limit();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule